// File: doc/BRIEF.md
# Serial Audio Channel Realignment Shifter

This block sits between a digital audio receiver or decoder and a pair of single-channel DACs. The source sends a serial stereo stream with a bit clock and a word (left/right) clock. Each DAC expects its own word to be aligned to a particular bit-clock position. The block reframes the stream for the DACs without resampling or filtering.

Every rising edge of the bit clock moves the serial data one place along a 48-stage delay line. Two taps are read from that line, one for the right-channel DAC and one for the left-channel DAC. The tap pair depends on two static selects: the source framing (I2S, or an alternate framing that places words later in the frame) and the word width of the DAC. Each channel leaves the block as a true signal and as its complement, so a balanced converter pair can be driven. The bit clock and the word clock are passed straight through to the converters, so the data and the clocks they were sent with stay in phase.

Top module: `audio_realign_shifter`

## Requirements
- R1: The right-channel tap N (in bit clocks) is set by `fmt_sel` and `width_sel`. `width_sel` codes are 0=16-bit, 1=18-bit, 2=20-bit and 3=24-bit. With `fmt_sel`=0 (I2S) the tap is 15, 13, 11 or 7 for those codes. With `fmt_sel`=1 (alternate framing) it is 24, 22, 20 or 16.
- R2: The left-channel tap is set the same way. With `fmt_sel`=0 it is 47, 45, 43 or 39 for width codes 0..3. With `fmt_sel`=1 it is 48, 46, 44 or 40.
- R3: A bit that `ser_data` holds at rising edge k of `bit_clk` appears on a channel with tap N just after edge k+N-1 and stays there until edge k+N.
- R4: `right_data_n` and `left_data_n` are always the bitwise complement of `right_data` and `left_data`, with no extra delay between the true and inverted outputs.
- R5: While `rst_n` is low at a rising edge of `bit_clk` (synchronous, active low), every stage of the delay line is cleared. From the next cycle on, `right_data` and `left_data` read 0 and `right_data_n` and `left_data_n` read 1.
- R6: `conv_bit_clk` follows `bit_clk` and `conv_word_clk` follows `word_clk` combinationally, with no register stage in between.
- R7: The left output repeats the right output delayed by a fixed number of bit clocks: 32 with `fmt_sel`=0 and 24 with `fmt_sel`=1.
- R8: A reset in the middle of a stream throws away every bit still in the line. After the reset is released, each output stays low until a new bit has travelled its full tap depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Source bit clock; the delay line shifts on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the delay line |
| fmt_sel | input | 1 | Source framing: 0 = I2S, 1 = alternate framing (static) |
| width_sel | input | 2 | DAC word width: 0=16, 1=18, 2=20, 3=24 bits (static) |
| ser_data | input | 1 | Serial audio data from the source |
| word_clk | input | 1 | Source word (left/right) clock |
| conv_bit_clk | output | 1 | Bit clock forwarded to the converters |
| conv_word_clk | output | 1 | Word clock forwarded to the converters |
| right_data | output | 1 | Right-channel data, true polarity |
| right_data_n | output | 1 | Right-channel data, inverted |
| left_data | output | 1 | Left-channel data, true polarity |
| left_data_n | output | 1 | Left-channel data, inverted |

## Verification
A stage that holds a wrong value shows up on a channel output only when that bit reaches the selected tap. A fault is therefore seen at most 48 bit clocks after it is made, and a fault beyond the active tap is never seen under that configuration. A wrong tap decode moves the whole stream by a fixed number of bit clocks. An impulse sent into the line shows this in the first cycle it comes out too early or too late, and the left/right spacing gives it away on any random stream. A reset that fails to clear shows on the outputs in the first cycle after the reset edge.

// File: rtl/realign_pkg.sv
// Package: realign_pkg
// Shared constants, types and the tap computation for the realignment shifter.
// Assumes the tap set is regular: within one framing each step up in the
// width code moves the right tap two bit clocks earlier, except the widest
// code, which moves it eight bit clocks earlier than the narrowest. The left
// tap is always the right tap plus a gap that depends on the framing.
package realign_pkg;

    localparam int LINE_DEPTH = 48;
    localparam int TAP_W      = $clog2(LINE_DEPTH + 1);
    localparam int CHANNELS   = 2;

    localparam int I2S_BASE   = 15;
    localparam int ALT_BASE   = 24;
    localparam int I2S_GAP    = 32;
    localparam int ALT_GAP    = 24;
    localparam int WIDTH_STEP = 2;
    localparam int WIDE_DROP  = 8;

    typedef enum logic [1:0] {
        WORD_16 = 2'd0,
        WORD_18 = 2'd1,
        WORD_20 = 2'd2,
        WORD_24 = 2'd3
    } word_width_e;

    typedef enum logic {
        FRAME_I2S = 1'b0,
        FRAME_ALT = 1'b1
    } frame_fmt_e;

    typedef struct packed {
        logic [TAP_W-1:0] right_tap;
        logic [TAP_W-1:0] left_tap;
    } tap_pair_t;

    // Works out the right and left tap depths for one framing/width choice.
    function automatic tap_pair_t taps_for(input frame_fmt_e fmt, input word_width_e wsel);
        int base;
        int gap;
        int right;
        tap_pair_t res;
        base = (fmt == FRAME_ALT) ? ALT_BASE : I2S_BASE;
        gap  = (fmt == FRAME_ALT) ? ALT_GAP  : I2S_GAP;
        if (wsel == WORD_24)
            right = base - WIDE_DROP;
        else
            right = base - WIDTH_STEP * int'(wsel);
        res.right_tap = TAP_W'(right);
        res.left_tap  = TAP_W'(right + gap);
        return res;
    endfunction

endpackage

// File: rtl/realign_delay_line.sv
// Module: realign_delay_line
// A serial shift chain clocked by the source bit clock. Stage 0 takes the
// input bit on every rising edge, and each later stage takes the value of
// the stage before it. The full chain is visible so that taps can be read.
// Assumes the reset is synchronous and active low; it clears every stage.
module realign_delay_line #(
    parameter int DEPTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] stages
);

    logic [DEPTH-1:0] chain_q;

    // Shifts one place per bit clock, or clears the chain while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[DEPTH-2:0], din};
    end

    assign stages = chain_q;

endmodule

// File: rtl/realign_tap_table.sv
// Module: realign_tap_table
// Turns the framing and width selects into right and left tap depths,
// using the computed rule in realign_pkg. It is purely combinational.
// Assumes the selects are static while data flows; a change takes effect
// at once on the taps but gives no clean frame boundary.
module realign_tap_table
    import realign_pkg::*;
#(
    parameter int TW = TAP_W
) (
    input  logic          fmt_sel,
    input  logic [1:0]    width_sel,
    output logic [TW-1:0] right_tap,
    output logic [TW-1:0] left_tap
);

    tap_pair_t pair;

    // Looks up the tap pair for the present selects.
    always_comb begin
        pair      = taps_for(frame_fmt_e'(fmt_sel), word_width_e'(width_sel));
        right_tap = TW'(pair.right_tap);
        left_tap  = TW'(pair.left_tap);
    end

endmodule

// File: rtl/realign_tap_mux.sv
// Module: realign_tap_mux
// Picks one stage of the delay line. Tap N means stage index N-1, so a bit
// comes out N rising edges after it entered, counting the edge that took it
// in. The select is decoded one-hot, and the stages are combined with an
// AND-OR tree of constant depth.
// Assumes the tap lies in 1..DEPTH; any other value gives 0.
module realign_tap_mux #(
    parameter int DEPTH = 48,
    parameter int TW    = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] stages,
    input  logic [TW-1:0]    tap,
    output logic             dout
);

    logic [DEPTH-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_tap
            assign hit[g] = (tap == TW'(g + 1)) & stages[g];
        end
    endgenerate

    // Combines the selected stage into a single output bit.
    always_comb begin
        dout = |hit;
    end

endmodule

// File: rtl/realign_out_pair.sv
// Module: realign_out_pair
// Drives one channel as a true and an inverted signal for a balanced DAC
// input. The two are produced in the same cycle with no register between
// them, so they switch together.
module realign_out_pair (
    input  logic din,
    output logic dout,
    output logic dout_n
);

    // Produces the true and complementary copies of the channel bit.
    always_comb begin
        dout   = din;
        dout_n = ~din;
    end

endmodule

// File: rtl/audio_realign_shifter.sv
// Module: audio_realign_shifter (top)
// Realigns a serial stereo stream for two single-channel DACs. Data moves
// through a delay line on the bit clock. The right and left channels are
// read from taps chosen by the framing and width selects, and each is sent
// out as a true and an inverted signal. The bit and word clocks go through
// without a register so they stay in phase with the data.
// Assumes fmt_sel and width_sel are static during operation, and that
// rst_n is synchronous to bit_clk and active low.
module audio_realign_shifter
    import realign_pkg::*;
#(
    parameter int DEPTH = LINE_DEPTH,
    parameter int TW    = $clog2(DEPTH + 1)
) (
    input  logic       bit_clk,
    input  logic       rst_n,
    input  logic       fmt_sel,
    input  logic [1:0] width_sel,
    input  logic       ser_data,
    input  logic       word_clk,
    output logic       conv_bit_clk,
    output logic       conv_word_clk,
    output logic       right_data,
    output logic       right_data_n,
    output logic       left_data,
    output logic       left_data_n
);

    localparam int RIGHT_CH = 0;
    localparam int LEFT_CH  = 1;

    logic [DEPTH-1:0] line_stages;
    logic [TW-1:0]    ch_tap  [CHANNELS];
    logic             ch_bit  [CHANNELS];
    logic             ch_true [CHANNELS];
    logic             ch_inv  [CHANNELS];

    realign_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk    (bit_clk),
        .rst_n  (rst_n),
        .din    (ser_data),
        .stages (line_stages)
    );

    realign_tap_table #(.TW(TW)) u_table (
        .fmt_sel   (fmt_sel),
        .width_sel (width_sel),
        .right_tap (ch_tap[RIGHT_CH]),
        .left_tap  (ch_tap[LEFT_CH])
    );

    genvar c;
    generate
        for (c = 0; c < CHANNELS; c++) begin : g_chan
            realign_tap_mux #(.DEPTH(DEPTH), .TW(TW)) u_mux (
                .stages (line_stages),
                .tap    (ch_tap[c]),
                .dout   (ch_bit[c])
            );
            realign_out_pair u_pair (
                .din    (ch_bit[c]),
                .dout   (ch_true[c]),
                .dout_n (ch_inv[c])
            );
        end
    endgenerate

    // Passes the clocks through and maps the channel outputs to the ports.
    always_comb begin
        conv_bit_clk  = bit_clk;
        conv_word_clk = word_clk;
        right_data    = ch_true[RIGHT_CH];
        right_data_n  = ch_inv[RIGHT_CH];
        left_data     = ch_true[LEFT_CH];
        left_data_n   = ch_inv[LEFT_CH];
    end

endmodule

// File: rtl/realign_checker.sv
// Module: realign_checker
// Assertions for audio_realign_shifter, attached to it with bind. A run
// counter counts bit clocks since reset release or since the last change
// of the selects, so that delayed comparisons only start once the line
// holds data from the current run.
module realign_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fmt_sel,
    input logic [1:0] width_sel,
    input logic       ser_data,
    input logic       right_data,
    input logic       right_data_n,
    input logic       left_data,
    input logic       left_data_n
);

    logic [6:0] run_cnt;
    logic [2:0] cfg_q;
    logic       rst_seen_q;

    // Counts settled cycles and restarts on reset or on a change of the selects.
    always_ff @(posedge clk) begin
        cfg_q <= {fmt_sel, width_sel};
        if (!rst_n || (cfg_q != {fmt_sel, width_sel}))
            run_cnt <= '0;
        else if (run_cnt != 7'd127)
            run_cnt <= run_cnt + 7'd1;
    end

    // R5: the cycle after a reset edge, all outputs show the cleared line.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            assert_reset_clear_R5: assert (!right_data && !left_data && right_data_n && left_data_n)
                else $error("outputs not cleared after reset");
        end
    end

    // R7: with I2S framing, the left output trails the right output by 32 cycles.
    assert_i2s_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 7'd50 && !fmt_sel) |-> (left_data == $past(right_data, 32)));

    // R7: with alternate framing, the left output trails the right output by 24 cycles.
    assert_alt_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 7'd50 && fmt_sel) |-> (left_data == $past(right_data, 24)));

    // R1, R3: I2S framing with a 24-bit DAC puts the right channel 7 bit clocks behind the input.
    assert_i2s24_right_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 7'd50 && !fmt_sel && width_sel == 2'd3) |-> (right_data == $past(ser_data, 7)));

    // R2, R3: alternate framing with a 16-bit DAC puts the left channel 48 bit clocks behind the input.
    assert_alt16_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 7'd50 && fmt_sel && width_sel == 2'd0) |-> (left_data == $past(ser_data, 48)));

    // R4: once the line has settled, the inverted outputs still track the true outputs.
    assert_complement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 7'd1) |-> (right_data_n != right_data && left_data_n != left_data));

endmodule

bind audio_realign_shifter realign_checker u_chk (
    .clk          (bit_clk),
    .rst_n        (rst_n),
    .fmt_sel      (fmt_sel),
    .width_sel    (width_sel),
    .ser_data     (ser_data),
    .right_data   (right_data),
    .right_data_n (right_data_n),
    .left_data    (left_data),
    .left_data_n  (left_data_n)
);

// File: tb/sim_audio_realign_shifter.sv
// Bench for audio_realign_shifter. A table of the eight configurations with
// their expected tap pairs is walked by one loop that sends a pseudo-random
// stream. Directed tests for reset, impulse timing and a reset in mid-stream
// follow.
module sim_audio_realign_shifter;

    logic       bit_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fmt_sel = 1'b0;
    logic [1:0] width_sel = 2'd0;
    logic       ser_data = 1'b0;
    logic       word_clk = 1'b0;
    logic       conv_bit_clk, conv_word_clk;
    logic       right_data, right_data_n, left_data, left_data_n;

    int         total = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [63:0] exp_sr = '0;
    int         wc_cnt = 0;
    logic       obs_r [0:127];
    logic [15:0] lfsr = 16'hACE1;

    // {fmt, width code, right tap, left tap}
    localparam logic [14:0] CFG_TAB [8] = '{
        {1'b0, 2'd0, 6'd15, 6'd47},
        {1'b0, 2'd1, 6'd13, 6'd45},
        {1'b0, 2'd2, 6'd11, 6'd43},
        {1'b0, 2'd3, 6'd7,  6'd39},
        {1'b1, 2'd0, 6'd24, 6'd48},
        {1'b1, 2'd1, 6'd22, 6'd46},
        {1'b1, 2'd2, 6'd20, 6'd44},
        {1'b1, 2'd3, 6'd16, 6'd40}
    };

    always #10 bit_clk = ~bit_clk;

    audio_realign_shifter u0 (
        .bit_clk       (bit_clk),
        .rst_n         (rst_n),
        .fmt_sel       (fmt_sel),
        .width_sel     (width_sel),
        .ser_data      (ser_data),
        .word_clk      (word_clk),
        .conv_bit_clk  (conv_bit_clk),
        .conv_word_clk (conv_word_clk),
        .right_data    (right_data),
        .right_data_n  (right_data_n),
        .left_data     (left_data),
        .left_data_n   (left_data_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drives one bit at the falling edge, updates the model at the rising edge, then waits a quarter period.
    task automatic step(input logic b);
        @(negedge bit_clk);
        ser_data = b;
        wc_cnt++;
        if (wc_cnt == 32) begin
            wc_cnt   = 0;
            word_clk = ~word_clk;
        end
        @(posedge bit_clk);
        if (!rst_n)
            exp_sr = '0;
        else
            exp_sr = {exp_sr[62:0], b};
        #5;
    endtask

    task automatic check_cleared(input string req);
        check(req, right_data, 1'b0);
        check(req, left_data, 1'b0);
        check(req, right_data_n, 1'b1);
        check(req, left_data_n, 1'b1);
    endtask

    task automatic configure(input logic f, input logic [1:0] w);
        @(negedge bit_clk);
        fmt_sel   = f;
        width_sel = w;
        rst_n     = 1'b0;
        step(1'b0);
        step(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge bit_clk);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R5: reset state from power-up.
        configure(1'b0, 2'd0);
        check_cleared("R5 reset state");

        // Walk the configuration table with a random stream.
        for (int row = 0; row < 8; row++) begin
            logic f;
            logic [1:0] w;
            int rt, lt, gap;
            f   = CFG_TAB[row][14];
            w   = CFG_TAB[row][13:12];
            rt  = int'(CFG_TAB[row][11:6]);
            lt  = int'(CFG_TAB[row][5:0]);
            gap = lt - rt;
            configure(f, w);
            check_cleared("R5 reset per config");
            rst_n = 1'b1;
            for (int k = 0; k < 90; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[0]);
                check("R1 right tap", right_data, exp_sr[rt-1]);
                check("R2 left tap", left_data, exp_sr[lt-1]);
                check("R4 right inverted", right_data_n, ~right_data);
                check("R4 left inverted", left_data_n, ~left_data);
                obs_r[k] = right_data;
                if (k >= gap)
                    check("R7 left trails right", left_data, obs_r[k-gap]);
                check("R6 word clock", conv_word_clk, word_clk);
                check("R6 bit clock high", conv_bit_clk, bit_clk);
            end
        end

        // R6: forwarded bit clock while the clock is low.
        @(negedge bit_clk);
        #1;
        check("R6 bit clock low", conv_bit_clk, 1'b0);

        // R3: impulse through I2S 16-bit taps (right 15, left 47).
        configure(1'b0, 2'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 52; i++) begin
            step(i == 0);
            check("R3 right impulse timing", right_data, (i == 14));
            check("R3 left impulse timing", left_data, (i == 46));
        end

        // R8: reset in mid-stream, alternate framing 16-bit (right 24, left 48).
        configure(1'b1, 2'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 60; i++) step(1'b1);
        check("R8 line filled right", right_data, 1'b1);
        check("R8 line filled left", left_data, 1'b1);
        rst_n = 1'b0;
        step(1'b1);
        check_cleared("R8 mid-stream reset");
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step(1'b1);
            check("R8 right after reset", right_data, (i >= 23));
            check("R8 left after reset", left_data, 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule